// File: doc/BRIEF.md
# Texture Gather Result Formatter

This block turns a 2x2 bilinear footprint into register writes for a gather that returns a single channel. It receives four unfiltered texels, each holding up to four 32-bit channels, together with a flag per channel that says whether the texture format provides it. It selects one post-swizzle channel from every texel. If half precision is enabled, it converts that channel to FP16. It then writes the four samples as two 64-bit register-pair writes.

One gather is accepted through a valid/ready handshake. The first pair goes to the first destination base and the second pair goes to the second destination base, each over its own valid/ready write handshake. A base index that is not even cannot hold a register pair. Such a base produces a one-cycle error pulse in place of its write. The block holds no more than one gather at a time.

Top module: `tex_gather_fmt`

## Requirements
- R1: `in_chan_sel` selects the channel word taken from every texel: 0 takes word 0 (red), 1 takes word 1 (green), 2 takes word 2 (blue), 3 takes word 3 (alpha), where `in_texels[s][c]` is channel c of sample s.
- R2: When `in_chan_present[in_chan_sel]` is 0, all four returned samples are zero in both precisions.
- R3: Sample s is texel `in_texels[s]`, counted counter-clockwise from the lower-left texel. The first pair carries sample 0 in `wr_data[31:0]` (even register) and sample 1 in `wr_data[63:32]` (odd register). The second pair carries samples 2 and 3 in the same places.
- R4: The pair for `in_dst0` is presented in the cycle after the input handshake. The pair for `in_dst1` is presented in the cycle after the first slot completes. A write holds `wr_valid`, `wr_idx` and `wr_data` stable until `wr_ready` is seen.
- R5: A base index with bit 0 set suppresses its write. `align_err` is high for exactly one cycle in that slot, and `wr_valid` stays low in that slot.
- R6: With `in_half_en` = 0, each sample is the selected 32-bit channel word, unchanged.
- R7: With `in_half_en` = 1, each sample is FP16 in bits 15:0 of its register, and bits 31:16 are zero.
- R8: With `in_rnd_mode` = 0, FP16 conversion rounds to nearest with ties to even. Magnitudes that round beyond 65504 become infinity (0x7C00 with the sign).
- R9: With `in_rnd_mode` = 1, FP16 conversion truncates toward zero. Finite overflow saturates to 0x7BFF with the sign.
- R10: Conversion of special values: NaN becomes sign|0x7E00, infinity stays infinity, and fp32 zero or denormal becomes a signed zero. Results below 2^-14 are encoded as FP16 subnormals.
- R11: `in_ready` is low from the input handshake until the second slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Gather request valid |
| in_ready | output | 1 | Block can accept a gather |
| in_texels | input | 4x4x32 | Footprint texels, [sample][channel] |
| in_chan_present | input | 4 | Channel present in the texture format |
| in_chan_sel | input | 2 | Returned channel (R, G, B, A) |
| in_half_en | input | 1 | Return FP16 instead of 32-bit words |
| in_rnd_mode | input | 1 | 0 nearest-even, 1 toward zero |
| in_dst0 | input | 8 | Base register index for samples 0 and 1 |
| in_dst1 | input | 8 | Base register index for samples 2 and 3 |
| wr_valid | output | 1 | Register-pair write valid |
| wr_ready | input | 1 | Register file accepts the write |
| wr_idx | output | 8 | Even base register index of the pair |
| wr_data | output | 64 | {odd register, even register} |
| align_err | output | 1 | One-cycle pulse for a suppressed misaligned pair |

## Verification
Gathers cycle through all four channel selects. Each channel word holds a different value, so a wrong select or a swapped sample position shows up directly in the data. Some gathers mark the selected channel absent, which separates zero fill from passthrough. FP16 gathers mix random mid-range values with a set of exact corner inputs: a rounding tie, a value just above a tie, the largest finite value, the first value that rounds over the top, the smallest subnormals, NaN and infinities. These are sent under both rounding modes, so the two rules give visibly different results. Odd base indices on either pair, together with irregular write stalls, check the error slot, the slot order and the holding of data while the write is not accepted.

// File: rtl/tg_pkg.sv
// Package: shared constants and types of the texture gather formatter.
// Assumes four samples per footprint and four channels per texel.
package tg_pkg;
    localparam int NUM_SMP = 4;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = 32;
    localparam int HALF_W  = 16;
    localparam int SEL_W   = $clog2(NUM_CH);

    typedef enum logic {
        RND_NEAREST_EVEN = 1'b0,
        RND_TOWARD_ZERO  = 1'b1
    } rnd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PAIR0 = 2'd1,
        SEQ_PAIR1 = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tg_chan_pick.sv
// Module: picks one channel word from a texel and zeroes it when the
// texture format does not provide that channel. Purely combinational.
module tg_chan_pick #(
    parameter int NCH = 4,
    parameter int W   = 32,
    localparam int SW = $clog2(NCH)
) (
    input  logic [NCH-1:0][W-1:0] chans,
    input  logic [NCH-1:0]        present,
    input  logic [SW-1:0]         sel,
    output logic [W-1:0]          value
);
    // Select the requested word, or zero fill for an absent channel.
    always_comb begin
        value = present[sel] ? chans[sel] : '0;
    end
endmodule

// File: rtl/tg_fp16_cvt.sv
// Module: fp32 to fp16 conversion with round-to-nearest-even or
// round-toward-zero. Assumes fp32 denormals flush to signed zero.
// Purely combinational.
module tg_fp16_cvt (
    input  logic [31:0] a,
    input  logic        rtz,
    output logic [15:0] h
);
    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] man;
    logic [23:0] sig;
    logic [7:0]  sh;
    logic [4:0]  sh_c;
    logic [47:0] ext;
    logic [4:0]  ex16;
    logic        rnd_up;
    logic [14:0] mag;

    assign sgn = a[31];
    assign ex  = a[30:23];
    assign man = a[22:0];
    assign sig = {1'b1, man};

    // Right-shift amount for results in the fp16 subnormal range.
    always_comb begin
        sh   = 8'd126 - ex;
        sh_c = (sh > 8'd26) ? 5'd26 : sh[4:0];
        ext  = {sig, 24'b0} >> sh_c;
        ex16 = 5'(ex - 8'd112);
    end

    // Classify the input and build the rounded fp16 magnitude.
    always_comb begin
        rnd_up = 1'b0;
        mag    = '0;
        if (ex == 8'hFF) begin
            mag = (man != 23'd0) ? 15'h7E00 : 15'h7C00;
        end else if (ex == 8'h00) begin
            mag = '0;
        end else if (ex > 8'd142) begin
            mag = rtz ? 15'h7BFF : 15'h7C00;
        end else if (ex >= 8'd113) begin
            rnd_up = !rtz && man[12] && ((|man[11:0]) || man[13]);
            mag    = {ex16, man[22:13]} + 15'(rnd_up);
        end else begin
            rnd_up = !rtz && ext[23] && ((|ext[22:0]) || ext[24]);
            mag    = 15'(ext[47:24]) + 15'(rnd_up);
        end
        h = {sgn, mag};
    end

    // R9: truncation of a finite value never yields an infinity or NaN code.
    always_comb begin
        if (rtz && ex != 8'hFF) begin
            assert_rtz_finite_R9: assert (h[14:10] != 5'h1F);
        end
    end
endmodule

// File: rtl/tg_pair_seq.sv
// Module: captures the four formatted samples and the two bases, then
// issues the two register-pair slots in order. A misaligned base turns
// its slot into a one-cycle error pulse. One gather in flight at most.
module tg_pair_seq
    import tg_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NUM_SMP-1:0][W-1:0] words,
    input  logic [IDX_W-1:0]        dst0,
    input  logic [IDX_W-1:0]        dst1,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [2*W-1:0]          wr_data,
    output logic                    align_err
);
    seq_state_e                 state;
    logic [NUM_SMP-1:0][W-1:0]  words_q;
    logic [IDX_W-1:0]           base0_q;
    logic [IDX_W-1:0]           base1_q;
    logic                       busy;
    logic                       slot1;
    logic [IDX_W-1:0]           cur_base;
    logic                       misaligned;
    logic                       slot_done;

    // Decode the current slot and its base index.
    always_comb begin
        busy       = (state != SEQ_IDLE);
        slot1      = (state == SEQ_PAIR1);
        cur_base   = slot1 ? base1_q : base0_q;
        misaligned = cur_base[0];
        in_ready   = !busy;
        wr_valid   = busy && !misaligned;
        align_err  = busy && misaligned;
        wr_idx     = cur_base;
        wr_data    = slot1 ? {words_q[3], words_q[2]} : {words_q[1], words_q[0]};
        slot_done  = align_err || (wr_valid && wr_ready);
    end

    // Slot state machine and capture of the accepted gather.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            words_q <= '0;
            base0_q <= '0;
            base1_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (in_valid) begin
                    state   <= SEQ_PAIR0;
                    words_q <= words;
                    base0_q <= dst0;
                    base1_q <= dst1;
                end
                SEQ_PAIR0: if (slot_done) state <= SEQ_PAIR1;
                SEQ_PAIR1: if (slot_done) state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // R4: a stalled write keeps its index and data.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_data)));

    // R5: an error slot and a write never coincide.
    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && align_err));

    // R5: every issued write targets an even base.
    assert_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_idx[0]);

    // R11: while accepting, nothing of an older gather is still pending.
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!wr_valid && !align_err));

    // R11: an accepted gather closes the input for the next cycle.
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/tex_gather_fmt.sv
// Module: top of the texture gather result formatter. Selects one channel
// per footprint texel, optionally converts it to fp16 in the low half of
// the register, and hands the four words to the pair sequencer.
// Assumes inputs are stable while in_valid is high.
module tex_gather_fmt
    import tg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [NUM_SMP-1:0][NUM_CH-1:0][CH_W-1:0] in_texels,
    input  logic [NUM_CH-1:0]                      in_chan_present,
    input  logic [SEL_W-1:0]                       in_chan_sel,
    input  logic                                   in_half_en,
    input  logic                                   in_rnd_mode,
    input  logic [IDX_W-1:0]                       in_dst0,
    input  logic [IDX_W-1:0]                       in_dst1,
    output logic                                   wr_valid,
    input  logic                                   wr_ready,
    output logic [IDX_W-1:0]                       wr_idx,
    output logic [2*CH_W-1:0]                      wr_data,
    output logic                                   align_err
);
    logic [NUM_SMP-1:0][CH_W-1:0] picked;
    logic [NUM_SMP-1:0][HALF_W-1:0] halves;
    logic [NUM_SMP-1:0][CH_W-1:0] words;
    logic                         rtz;

    assign rtz = (rnd_mode_e'(in_rnd_mode) == RND_TOWARD_ZERO);

    for (genvar s = 0; s < NUM_SMP; s++) begin : g_smp
        tg_chan_pick #(.NCH(NUM_CH), .W(CH_W)) u_pick (
            .chans   (in_texels[s]),
            .present (in_chan_present),
            .sel     (in_chan_sel),
            .value   (picked[s])
        );

        tg_fp16_cvt u_cvt (
            .a   (picked[s]),
            .rtz (rtz),
            .h   (halves[s])
        );

        // Full word or zero-extended fp16, no partial register content.
        always_comb begin
            words[s] = in_half_en ? {{(CH_W-HALF_W){1'b0}}, halves[s]} : picked[s];
        end
    end

    tg_pair_seq #(.IDX_W(IDX_W), .W(CH_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .words     (words),
        .dst0      (in_dst0),
        .dst1      (in_dst1),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .align_err (align_err)
    );
endmodule

// File: tb/test_tex_gather_fmt.sv
module test_tex_gather_fmt;
    localparam int NG = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [3:0][3:0][31:0] in_texels = '0;
    logic [3:0] in_chan_present = '0;
    logic [1:0] in_chan_sel = '0;
    logic in_half_en = 1'b0;
    logic in_rnd_mode = 1'b0;
    logic [7:0] in_dst0 = '0;
    logic [7:0] in_dst1 = '0;
    logic wr_valid;
    logic wr_ready = 1'b0;
    logic [7:0] wr_idx;
    logic [63:0] wr_data;
    logic align_err;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit          is_err;
        logic [7:0]  idx;
        logic [63:0] data;
        bit          half;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    tex_gather_fmt i_tex_gather_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_texels(in_texels), .in_chan_present(in_chan_present),
        .in_chan_sel(in_chan_sel), .in_half_en(in_half_en),
        .in_rnd_mode(in_rnd_mode), .in_dst0(in_dst0), .in_dst1(in_dst1),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
        .wr_data(wr_data), .align_err(align_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Reference fp16 conversion, written as integer scaling.
    function automatic logic [15:0] ref_half(input logic [31:0] a, input bit rtz);
        int ex, e, e16, s, enc;
        longint sig, q, rem, half;
        ex = int'(a[30:23]);
        if (ex == 255) return (a[22:0] != 0) ? {a[31], 15'h7E00} : {a[31], 15'h7C00};
        if (ex == 0) return {a[31], 15'h0000};
        e = ex - 127;
        if (e > 15) return rtz ? {a[31], 15'h7BFF} : {a[31], 15'h7C00};
        e16 = (e < -14) ? -14 : e;
        s = 13 + (e16 - e);
        if (s > 40) s = 40;
        sig = 64'sd8388608 + longint'(a[22:0]);
        q = sig >>> s;
        rem = sig - (q <<< s);
        half = 64'sd1 <<< (s - 1);
        if (!rtz && (rem > half || (rem == half && q[0]))) q = q + 1;
        enc = (e16 + 14) * 1024 + int'(q);
        if (enc >= 31744) enc = rtz ? 31743 : 31744;
        return {a[31], 15'(enc)};
    endfunction

    function automatic logic [31:0] special(input int k);
        case (k % 12)
            0:  return 32'h3F800000; // 1.0
            1:  return 32'h3F801000; // tie, stays 1.0 under nearest-even
            2:  return 32'h3F803000; // tie, rounds to even upward
            3:  return 32'h477FE000; // 65504
            4:  return 32'h477FF000; // rounds over the top
            5:  return 32'h33800000; // 2^-24 smallest subnormal
            6:  return 32'h33000000; // 2^-25 tie to zero
            7:  return 32'h7FC00001; // NaN
            8:  return 32'hFF800000; // -inf
            9:  return 32'h80000000; // -0
            10: return 32'h00400000; // fp32 denormal
            default: return 32'hB8FFF000; // near min normal
        endcase
    endfunction

    task automatic load(input int g);
        in_chan_sel = 2'(g % 4);
        in_chan_present = (g % 5 == 2) ? ~(4'b1 << (g % 4)) : 4'hF;
        in_half_en = ((g / 4) % 2) == 1;
        in_rnd_mode = ((g / 8) % 2) == 1;
        in_dst0 = 8'((g * 6) % 200) | ((g % 7 == 3) ? 8'd1 : 8'd0);
        in_dst1 = 8'((g * 6 + 2) % 200) | ((g % 11 == 5) ? 8'd1 : 8'd0);
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                if (g % 3 == 0)
                    in_texels[s][c] = special(g * 4 + s * 3 + c);
                else
                    in_texels[s][c] = {1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)};
            end
        end
    endtask

    function automatic logic [31:0] exp_word(input int s);
        if (!in_chan_present[in_chan_sel]) return 32'h0;
        if (in_half_en) return {16'h0, ref_half(in_texels[s][in_chan_sel], in_rnd_mode)};
        return in_texels[s][in_chan_sel];
    endfunction

    task automatic push_expect();
        exp_t e0, e1;
        string tag;
        if (!in_chan_present[in_chan_sel]) tag = "R2";
        else if (!in_half_en) tag = "R1 R6";
        else tag = in_rnd_mode ? "R9 R10" : "R8 R10";
        e0.is_err = in_dst0[0]; e0.idx = in_dst0; e0.half = in_half_en;
        e0.data = {exp_word(1), exp_word(0)}; e0.tag = {"R3 ", tag};
        e1.is_err = in_dst1[0]; e1.idx = in_dst1; e1.half = in_half_en;
        e1.data = {exp_word(3), exp_word(2)}; e1.tag = {"R3 ", tag};
        expq.push_back(e0);
        expq.push_back(e1);
    endtask

    initial begin
        int g = 0;
        int cyc = 0;
        bit acc = 0;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R11 reset", 64'(in_ready), 64'd1);
        check(wr_valid == 1'b0 && align_err == 1'b0, "R4 reset", {62'd0, wr_valid, align_err}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(g >= NG && expq.size() == 0 && !in_valid)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "watchdog", 64'(cyc), 64'd20000);
                break;
            end
            if (acc) begin in_valid = 1'b0; acc = 0; end
            wr_ready = ((cyc / 7) % 3 == 1) ? 1'b0 : ($urandom % 4 != 0);
            if (!in_valid && g < NG && $urandom % 4 != 0) begin
                load(g);
                in_valid = 1'b1;
            end
            #1;
            // R11: input open only when nothing is pending
            check(in_ready == (expq.size() == 0), "R11", 64'(in_ready), 64'(expq.size() == 0));
            if (expq.size() > 0) begin
                // R4: the front slot is presented, as write or as error pulse
                check((wr_valid ^ align_err) == 1'b1, "R4 slot", {62'd0, wr_valid, align_err}, 64'd0);
                if (expq[0].is_err) begin
                    check(align_err && !wr_valid, "R5", {62'd0, wr_valid, align_err}, 64'd1);
                    expq.pop_front();
                end else if (wr_valid) begin
                    check(wr_idx == expq[0].idx, "R4 index", 64'(wr_idx), 64'(expq[0].idx));
                    check(wr_data == expq[0].data, expq[0].tag, wr_data, expq[0].data);
                    if (expq[0].half)
                        check(wr_data[63:48] == 16'h0 && wr_data[31:16] == 16'h0, "R7",
                              wr_data, wr_data & 64'h0000FFFF0000FFFF);
                    if (wr_ready) expq.pop_front();
                end
            end else begin
                check(!wr_valid && !align_err, "R4 idle", {62'd0, wr_valid, align_err}, 64'd0);
            end
            if (in_valid && in_ready) begin
                push_expect();
                acc = 1;
                g++;
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule